// File: doc/BRIEF.md
# Nested Stack-Frame Builder

This block carries out the frame set-up and tear-down of a block-structured language on a 32-bit, downward-growing stack. On an enter operation it takes a byte count for local storage and a lexical nesting level. It saves the caller's frame pointer, copies the caller's chain of outer frame pointers (the display) into the new frame, and points the frame pointer at the new frame. It then moves the stack pointer down past the local area. On a leave operation it drops the whole frame and reloads the caller's frame pointer.

The surrounding pipeline supplies the current frame and stack pointers and pulses `start`, with `op_leave` choosing between the two operations. The block then works through a single word-wide stack-memory port, one access at a time, with a request/acknowledge handshake. When it finishes it presents the new pointer pair and pulses `done`. Nothing outside the frame sequence is handled here: instruction decode, alignment checks and faults belong to the caller.

Top module: `frame_seq`

## Requirements
- R1: After reset, `done` and `mem_req` are low and `fp_out` and `sp_out` read zero.
- R2: The first access of an enter is a write of `fp_in` to address `sp_in - 4`. That address is the new frame pointer, called F below.
- R3: An enter at level 0 makes exactly one access. It then gives `fp_out = F` and `sp_out = F - size_in`.
- R4: An enter at level L > 0 performs L-1 display copies. Copy i (i = 1..L-1) reads address `fp_in - 4*i` and then writes the word it read to `F - 4*i`. The copies run in increasing order of i, read before write. A final write stores F at `F - 4*L`.
- R5: An enter at level L > 0 ends with `fp_out = F` and `sp_out = F - 4*L - size_in`. Here `size_in` is a 16-bit unsigned count, zero-extended.
- R6: A leave makes exactly one access, a read at `fp_in`. It ends with `fp_out` equal to the word read and `sp_out = fp_in + 4`, and it makes no write.
- R7: `done` is a one-cycle pulse. It rises in the cycle after the acknowledge of the operation's last access, and `mem_req` is low while `done` is high.
- R8: While an operation is in progress, `start` is ignored. The running operation's accesses and results are unchanged.
- R9: Once raised, `mem_req` stays high until `mem_ack` is seen. Address, write enable and write data hold steady while it waits.
- R10: The level operand is 5 bits wide, so levels 0 to 31 are accepted. Level 31 performs 30 display copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_leave | input | 1 | 1 = leave (release frame), 0 = enter (build frame) |
| size_in | input | 16 | Local storage size in bytes (enter only) |
| level_in | input | 5 | Lexical nesting level (enter only) |
| fp_in | input | 32 | Current frame pointer |
| sp_in | input | 32 | Current stack pointer |
| fp_out | output | 32 | Frame pointer after the last operation |
| sp_out | output | 32 | Stack pointer after the last operation |
| mem_req | output | 1 | Stack-memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Access completed this cycle |
| done | output | 1 | Operation complete (one-cycle pulse) |

## Verification
The bench works through levels 0, 1, 2, 4 and 31. A design with an off-by-one copy count shows up here as an extra or missing display access, or as a second push of the new frame pointer at level 0. Reads come from an area pre-filled with address-tagged words, so a copy that walks the wrong direction writes a visibly wrong value. The same holds for a copy that reads through the already-moved stack pointer. A large storage size exposes sign extension, because the stack pointer would then move up rather than down. Leave operations follow enters on the same memory, and a start pulse arrives in mid-operation with acknowledge latency varied. Together these catch a leave that writes, a pointer pair updated too early, a `done` that comes late or lasts two cycles, and a busy block that restarts.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 16,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_leave,
  input  logic [SIZE_W-1:0] size_in,
  input  logic [LVL_W-1:0]  level_in,
  input  logic [DATA_W-1:0] fp_in,
  input  logic [DATA_W-1:0] sp_in,
  output logic [DATA_W-1:0] fp_out,
  output logic [DATA_W-1:0] sp_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              done
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} state_t;
  typedef enum logic [1:0] {P_OLD, P_DISP, P_NEW, P_LEAVE} phase_t;

  state_t            st;
  phase_t            ph;
  logic [DATA_W-1:0] sp_w, fp_w, fnew, addr_q, wdat_q, fp_q, sp_q;
  logic [LVL_W-1:0]  lvl_q, left_q;
  logic [SIZE_W-1:0] size_q;
  logic              done_q;

  wire [DATA_W-1:0] size_ext = {{(DATA_W-SIZE_W){1'b0}}, size_q};

  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign fp_out    = fp_q;
  assign sp_out    = sp_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= P_OLD;
      sp_w   <= '0;
      fp_w   <= '0;
      fnew   <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      fp_q   <= '0;
      sp_q   <= '0;
      lvl_q  <= '0;
      left_q <= '0;
      size_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          if (op_leave) begin
            addr_q <= fp_in;
            sp_w   <= fp_in;
            ph     <= P_LEAVE;
            st     <= S_RD;
          end else begin
            sp_w   <= sp_in - STEP;
            addr_q <= sp_in - STEP;
            wdat_q <= fp_in;
            fp_w   <= fp_in;
            lvl_q  <= level_in;
            size_q <= size_in;
            ph     <= P_OLD;
            st     <= S_WR;
          end
        end
        S_RD: if (mem_ack) begin
          if (ph == P_LEAVE) begin
            fp_q   <= mem_rdata;
            sp_q   <= sp_w + STEP;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            sp_w   <= sp_w - STEP;
            addr_q <= sp_w - STEP;
            wdat_q <= mem_rdata;
            st     <= S_WR;
          end
        end
        S_WR: if (mem_ack) begin
          unique case (ph)
            P_OLD: begin
              fnew <= sp_w;
              if (lvl_q == '0) begin
                fp_q   <= sp_w;
                sp_q   <= sp_w - size_ext;
                done_q <= 1'b1;
                st     <= S_IDLE;
              end else if (lvl_q == LVL_W'(1)) begin
                sp_w   <= sp_w - STEP;
                addr_q <= sp_w - STEP;
                wdat_q <= sp_w;
                ph     <= P_NEW;
              end else begin
                left_q <= lvl_q - LVL_W'(1);
                fp_w   <= fp_w - STEP;
                addr_q <= fp_w - STEP;
                ph     <= P_DISP;
                st     <= S_RD;
              end
            end
            P_DISP: begin
              if (left_q == LVL_W'(1)) begin
                sp_w   <= sp_w - STEP;
                addr_q <= sp_w - STEP;
                wdat_q <= fnew;
                ph     <= P_NEW;
              end else begin
                left_q <= left_q - LVL_W'(1);
                fp_w   <= fp_w - STEP;
                addr_q <= fp_w - STEP;
                st     <= S_RD;
              end
            end
            default: begin
              fp_q   <= fnew;
              sp_q   <= sp_w - size_ext;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module frame_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              done
);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ack));

  a_r7_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> ((mem_req && mem_we) || done));
endmodule

bind frame_seq frame_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
);

// File: tb/tb_frame_seq.sv
module tb_frame_seq;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic        lv;
    logic [4:0]  lvl;
    logic [15:0] sz;
    logic [31:0] fp;
    logic [31:0] sp;
    logic [31:0] efp;
    logic [31:0] esp;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd0, 16'h0010, 32'h0F00, 32'h0800, 32'h07FC, 32'h07EC, 2'd0},
    '{1'b1, 5'd0, 16'h0000, 32'h07FC, 32'h0123, 32'h0F00, 32'h0800, 2'd1},
    '{1'b0, 5'd1, 16'h0000, 32'h0E00, 32'h0700, 32'h06FC, 32'h06F8, 2'd2},
    '{1'b0, 5'd4, 16'h0020, 32'h0D00, 32'h0600, 32'h05FC, 32'h05CC, 2'd0},
    '{1'b0, 5'd2, 16'hFFFC, 32'h0C00, 32'h0500, 32'h04FC, 32'hFFFF04F8, 2'd3},
    '{1'b1, 5'd0, 16'h0000, 32'h05FC, 32'h0000, 32'h0D00, 32'h0600, 2'd0}
  };

  logic clk = 0, rst_n = 0, start = 0, op_leave = 0, mem_ack = 0;
  logic [15:0] size_in = 0;
  logic [4:0]  level_in = 0;
  logic [31:0] fp_in = 0, sp_in = 0, mem_rdata = 0;
  logic [31:0] fp_out, sp_out, mem_addr, mem_wdata;
  logic mem_req, mem_we, done;

  frame_seq dut (.*);

  always #(PERIOD/2) clk = ~clk;

  logic [31:0] mem [1024];
  logic [31:0] lg_addr [80];
  logic [31:0] lg_data [80];
  logic        lg_we   [80];
  int nlog = 0, lat_cur = 0, wcnt = 0, cyc = 0, ack_cyc = 0, done_cyc = 0, done_cnt = 0;
  int checks = 0, errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req) begin
      if (wcnt >= lat_cur) begin
        mem_ack = 1'b1;
        wcnt = 0;
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          if (nlog < 80) begin lg_data[nlog] = mem_wdata; end
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
          if (nlog < 80) begin lg_data[nlog] = mem_rdata; end
        end
        if (nlog < 80) begin lg_addr[nlog] = mem_addr; lg_we[nlog] = mem_we; end
        nlog++;
        ack_cyc = cyc;
      end else wcnt++;
    end
    if (done) begin done_cnt++; done_cyc = cyc; end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'h5A000000 | a;
  endfunction

  task automatic run(input logic lv, input logic [4:0] lvl, input logic [15:0] sz,
                     input logic [31:0] fp, input logic [31:0] sp,
                     input logic [31:0] efp, input logic [31:0] esp,
                     input int lat, input logic poke);
    logic [31:0] ea [80];
    logic [31:0] ed [80];
    logic        ew [80];
    int n = 0, t = 0;
    @(negedge clk); #1;
    nlog = 0; done_cnt = 0; lat_cur = lat;
    op_leave = lv; level_in = lvl; size_in = sz; fp_in = fp; sp_in = sp; start = 1;
    @(negedge clk); #1;
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      #1;
      op_leave = 1; fp_in = 32'h07FC; start = 1;
      @(negedge clk); #1;
      start = 0;
    end
    while (done_cnt == 0 && t < 3000) begin @(negedge clk); #1; t++; end
    @(negedge clk); #1;
    chk(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
    chk(done_cyc == ack_cyc + 1, "R7 done one cycle after last ack", done_cyc, ack_cyc + 1);
    if (lv) begin
      ea[0] = fp; ew[0] = 0; ed[0] = efp; n = 1;
    end else begin
      ea[0] = sp - 4; ew[0] = 1; ed[0] = fp; n = 1;
      for (int i = 1; i < int'(lvl); i++) begin
        ea[n] = fp - 4*i;     ew[n] = 0; ed[n] = pat(fp - 4*i); n++;
        ea[n] = sp - 4 - 4*i; ew[n] = 1; ed[n] = pat(fp - 4*i); n++;
      end
      if (lvl != 0) begin ea[n] = sp - 4 - 4*lvl; ew[n] = 1; ed[n] = sp - 4; n++; end
    end
    chk(nlog == n, lv ? "R6 access count" : (lvl == 0 ? "R3 access count" : "R4 access count"), nlog, n);
    for (int k = 0; k < n && k < nlog; k++) begin
      chk(lg_addr[k] == ea[k], k == 0 ? (lv ? "R6 read address" : "R2 first address") : "R4 address", lg_addr[k], ea[k]);
      chk(lg_we[k] == ew[k], lv ? "R6 no write" : "R4 direction", lg_we[k], ew[k]);
      chk(lg_data[k] == ed[k], k == 0 && !lv ? "R2 saved frame pointer" : "R4 data", lg_data[k], ed[k]);
    end
    chk(fp_out == efp, lv ? "R6 fp_out" : "R5 fp_out", fp_out, efp);
    chk(sp_out == esp, lv ? "R6 sp_out" : (lvl == 0 ? "R3 sp_out" : "R5 sp_out"), sp_out, esp);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i) << 2);
    repeat (3) @(negedge clk);
    #1;
    chk(done == 0, "R1 done at reset", done, 0);
    chk(mem_req == 0, "R1 mem_req at reset", mem_req, 0);
    chk(fp_out == 0, "R1 fp_out at reset", fp_out, 0);
    chk(sp_out == 0, "R1 sp_out at reset", sp_out, 0);
    rst_n = 1;
    for (int v = 0; v < NV; v++)
      run(VECS[v].lv, VECS[v].lvl, VECS[v].sz, VECS[v].fp, VECS[v].sp,
          VECS[v].efp, VECS[v].esp, int'(VECS[v].lat), 1'b0);
    // R10: deepest level, 30 display copies
    run(1'b0, 5'd31, 16'h0008, 32'h0B00, 32'h0400, 32'h03FC, 32'h0378, 0, 1'b0);
    chk(mem[32'h03F8 >> 2] == 32'h5A000AFC, "R10 first display copy", mem[32'h03F8 >> 2], 32'h5A000AFC);
    chk(mem[32'h0380 >> 2] == 32'h03FC, "R10 new frame pointer pushed last", mem[32'h0380 >> 2], 32'h03FC);
    // R8: start pulse while busy is ignored
    run(1'b0, 5'd2, 16'h0000, 32'h0900, 32'h0300, 32'h02FC, 32'h02F4, 3, 1'b1);
    @(negedge clk); #1;
    chk(mem_req == 0, "R8 no restart after busy start", mem_req, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule